// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This block is a 16-bit up-counter that software reads and writes one byte at a time over a small register bus. Each count step comes from one of two sources. The internal source ticks once every four system clocks. The external source takes one step on each rising edge of an input pin. The external edge can be detected through a two-flop synchronizer, or it can be taken from the raw pin with one sampling flop for lower latency. Steps pass through a prescaler that divides by 1, 2, 4 or 8 before they reach the counter.

Counting can be qualified by a gate. The gate comes either from a dedicated gate pin or from a comparator output, and its active level is selectable. When the count wraps from FFFFh to 0000h, a sticky overflow flag is set. Software clears the flag by writing zero to it.

Top module: `gtimer16`

## Requirements
- R1: After reset, all four registers read 0: control (address 0), count low (address 1), count high (address 2) and flag (address 3).
- R2: A bus write to address 0, 1 or 2 stores the byte, and a read of the same address returns it. The read data is combinational on bus_addr.
- R3: With control bit 0 (run) set and control bit 1 (source) clear, a divide field of 0 advances the counter exactly once every 4 system clocks.
- R4: Control bits [4:3] select prescale division by 2^value (1, 2, 4 or 8). With this division, N steps from the selected source advance the counter by N / division.
- R5: With run clear, the count does not change, whatever the source or input activity.
- R6: An increment from FFFFh gives 0000h and sets the flag, which is read at address 3 bit 0. The flag then stays set.
- R7: Writing address 3 with bit 0 = 0 clears the flag, and writing it with bit 0 = 1 has no effect. When an overflow and a clear fall in the same cycle, the flag ends set.
- R8: With control bit 5 (gate enable) set, steps are counted only while the gate is active. Bit 6 selects the gate source: 0 is gate_in and 1 is cmp_in. Bit 7 set makes the gate active-low. With bit 5 clear, the gate has no effect.
- R9: With source set and control bit 2 clear (synchronized), each rising edge of ext_clk_in counts once. The count becomes visible after the third system clock edge that follows the pin rising.
- R10: With source set and control bit 2 set (bypass), each rising edge of ext_clk_in counts once. The count becomes visible after the first system clock edge that follows the pin rising.
- R11: Writing either count byte returns the prescaler to zero, so the next increment needs a full division of new steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high, 3 flag |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_clk_in | input | 1 | External count clock pin |
| gate_in | input | 1 | Dedicated gate pin |
| cmp_in | input | 1 | Comparator output used as an alternative gate |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that gate_in and cmp_in are stable with respect to clk, because the gate is used without synchronization. They also assume that in bypass mode ext_clk_in changes at most once per system clock. In synchronized mode, the pin must hold each level for at least two clocks. The bench changes every input at the falling clock edge and holds each external clock phase for three clocks, so all of these conditions hold throughout the run.

// File: rtl/gt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the gated timer: bus width, register select codes
// and the control byte layout. Assumes an 8-bit register bus.
package gt_pkg;
    localparam int unsigned BUS_W = 8;
    localparam int unsigned PRE_W = 2;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_FLAG   = 2'd3
    } reg_addr_e;

    // Control byte, MSB first: 7 gate_inv, 6 gate_from_cmp, 5 gate_on,
    // 4:3 pre_sel, 2 ext_bypass, 1 src_ext, 0 run.
    typedef struct packed {
        logic             gate_inv;
        logic             gate_from_cmp;
        logic             gate_on;
        logic [PRE_W-1:0] pre_sel;
        logic             ext_bypass;
        logic             src_ext;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/gt_tick_src.sv
`timescale 1ns/1ps
// Step source. Produces a one-cycle step pulse in the clk domain, taken
// either from a free-running internal divider or from rising edges of the
// external pin. The external path uses a SYNC_STAGES synchronizer, or in
// bypass mode a single sampling flop. Assumes that the pin holds each level
// for at least two clocks when it is synchronized.
module gt_tick_src #(
    parameter int unsigned DIV_INT     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic ext_bypass,
    input  logic ext_pin,
    output logic tick
);
    localparam int unsigned DIV_W = (DIV_INT > 2) ? $clog2(DIV_INT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_INT - 1);

    logic [DIV_W-1:0]       div_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   int_tick;
    logic                   edge_sync;
    logic                   edge_byp;

    // Internal divider: wraps every DIV_INT clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + DIV_W'(1);
    end

    // Synchronizer chain for the external pin.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= ext_pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    // Last synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Step selection: divider, synchronized edge or raw edge.
    always_comb begin
        int_tick  = (div_q == DIV_LAST);
        edge_sync = sync_q[SYNC_STAGES-1] & ~prev_q;
        edge_byp  = ext_pin & ~sync_q[0];
        if (!src_ext)        tick = int_tick;
        else if (ext_bypass) tick = edge_byp;
        else                 tick = edge_sync;
    end

    // R3
    int_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);

    // R9
    sync_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sync |=> !edge_sync);
endmodule

// File: rtl/gt_gate_pre.sv
`timescale 1ns/1ps
// Gate qualification and prescaler. A step is qualified by run and by the
// gate when the gate is enabled. Qualified steps advance a prescale counter,
// which emits one increment for each 2^pre_sel steps. pre_clr zeroes the
// prescale counter. Assumes that the gate inputs are synchronous to clk.
module gt_gate_pre #(
    parameter int unsigned PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate_on,
    input  logic             gate_from_cmp,
    input  logic             gate_inv,
    input  logic             gate_pin,
    input  logic             cmp_in,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             pre_clr,
    input  logic             tick_in,
    output logic             inc
);
    localparam int unsigned PCW = (1 << PRE_W) - 1;

    logic [PCW-1:0] pcnt_q;
    logic [PCW-1:0] limit;
    logic           gate_level;
    logic           gate_open;
    logic           qual;
    logic           at_lim;

    // Gate resolution and the terminal count for the selected division.
    always_comb begin
        gate_level = gate_from_cmp ? cmp_in : gate_pin;
        gate_open  = ~gate_on | (gate_level ^ gate_inv);
        qual       = tick_in & run & gate_open;
        limit      = (PCW'(1) << pre_sel) - PCW'(1);
        at_lim     = (pcnt_q >= limit);
        inc        = qual & at_lim;
    end

    // Prescale counter: cleared by a count write, otherwise steps and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)     pcnt_q <= '0;
        else if (pre_clr) pcnt_q <= '0;
        else if (qual)  pcnt_q <= at_lim ? '0 : pcnt_q + PCW'(1);
    end

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !(gate_level ^ gate_inv) && !pre_clr) |=> $stable(pcnt_q));

    // R4
    pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !pre_clr) |=> (pcnt_q == '0));

    // R11
    pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_clr |=> (pcnt_q == '0));
endmodule

// File: rtl/gt_count.sv
`timescale 1ns/1ps
// Count register and sticky overflow flag. A byte write takes priority over
// an increment in the same cycle. Overflow sets the flag, and the set wins
// over a clear in the same cycle. Assumes CNT_W <= 2*BUS_W.
module gt_count #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam int unsigned HI_W = CNT_W - BUS_W;

    logic wr_any;
    logic wrap;

    // Overflow occurs on an increment from all ones with no write pending.
    always_comb begin
        wr_any = wr_lo | wr_hi;
        wrap   = inc & (&count) & ~wr_any;
    end

    // Count register: byte writes first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_any) begin
            if (wr_lo) count[BUS_W-1:0]     <= wr_data;
            if (wr_hi) count[CNT_W-1:BUS_W] <= wr_data[HI_W-1:0];
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // R5
    cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi) |=> $stable(count));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&count) && !wr_lo && !wr_hi) |=> (flag && count == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/gtimer16.sv
`timescale 1ns/1ps
// Gated timer top. Holds the control register, decodes bus writes, joins
// step source, gate/prescaler and count register, and muxes read data.
// Assumes that the bus inputs are synchronous to clk and that CNT_W is
// 2*BUS_W.
module gtimer16 #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DIV_INT     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_clk_in,
    input  logic       gate_in,
    input  logic       cmp_in,
    output logic       ovf_flag
);
    import gt_pkg::*;

    localparam int unsigned HI_W = CNT_W - BUS_W;

    ctrl_t            ctrl_q;
    reg_addr_e        sel;
    logic             wr_ctrl;
    logic             wr_lo;
    logic             wr_hi;
    logic             flag_clr;
    logic             tick;
    logic             inc;
    logic [CNT_W-1:0] count;

    // Write decode.
    always_comb begin
        sel      = reg_addr_e'(bus_addr);
        wr_ctrl  = bus_we && (sel == REG_CTRL);
        wr_lo    = bus_we && (sel == REG_CNT_LO);
        wr_hi    = bus_we && (sel == REG_CNT_HI);
        flag_clr = bus_we && (sel == REG_FLAG) && !bus_wdata[0];
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
    end

    gt_tick_src #(
        .DIV_INT     (DIV_INT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_ext    (ctrl_q.src_ext),
        .ext_bypass (ctrl_q.ext_bypass),
        .ext_pin    (ext_clk_in),
        .tick       (tick)
    );

    gt_gate_pre #(
        .PRE_W (PRE_W)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (ctrl_q.run),
        .gate_on       (ctrl_q.gate_on),
        .gate_from_cmp (ctrl_q.gate_from_cmp),
        .gate_inv      (ctrl_q.gate_inv),
        .gate_pin      (gate_in),
        .cmp_in        (cmp_in),
        .pre_sel       (ctrl_q.pre_sel),
        .pre_clr       (wr_lo | wr_hi),
        .tick_in       (tick),
        .inc           (inc)
    );

    gt_count #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_data  (bus_wdata),
        .flag_clr (flag_clr),
        .count    (count),
        .flag     (ovf_flag)
    );

    // Read mux.
    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_CNT_LO: bus_rdata = count[BUS_W-1:0];
            REG_CNT_HI: bus_rdata = BUS_W'(count[CNT_W-1:CNT_W-HI_W]);
            default:    bus_rdata = {{(BUS_W-1){1'b0}}, ovf_flag};
        endcase
    end

    // R5
    run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: tb/sim_gtimer16.sv
`timescale 1ns/1ps
module sim_gtimer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0;
    logic       gate_in = 1'b0;
    logic       cmp_in = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gtimer16 u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .gate_in(gate_in), .cmp_in(cmp_in), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi, lo};
    endtask

    task automatic rd_flag(output logic f);
        logic [7:0] d;
        rd(2'd3, d);
        f = d[0];
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Control byte: {gate_inv, gate_from_cmp, gate_on, pre_sel[1:0], bypass, src_ext, run}
    function automatic logic [7:0] cfg(input bit run, input bit src, input bit byp,
                                       input logic [1:0] ps, input bit gon,
                                       input bit gsel, input bit ginv);
        return {ginv, gsel, gon, ps, byp, src, run};
    endfunction

    task automatic load(input logic [15:0] v);
        wr(2'd0, 8'h00);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
        wr(2'd3, 8'h00);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; cycles(3);
            ext_clk_in = 1'b0; cycles(3);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        logic        f;

        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reset read", d, 8'h00);
        end

        // R2 register write/readback
        wr(2'd0, 8'hFA); rd(2'd0, d); chk("R2 ctrl readback", d, 8'hFA);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h5A); wr(2'd2, 8'hC3);
        rd_cnt(v); chk("R2 count readback", v, 16'hC35A);

        // R3/R4/R6 internal source sweep over prescale and start values
        for (int ps = 0; ps < 4; ps++) begin
            for (int s = 0; s < 2; s++) begin
                logic [15:0] start;
                logic [16:0] sum;
                int k;
                start = (s == 0) ? 16'h1234 : 16'hFFFD;
                k = 5;
                load(start);
                wr(2'd0, cfg(1, 0, 0, 2'(ps), 0, 0, 0));
                cycles(4 * (1 << ps) * k);
                rd_cnt(v); rd_flag(f);
                sum = {1'b0, start} + 17'(k);
                chk(ps == 0 ? "R3 internal rate" : "R4 prescale count", v, sum[15:0]);
                chk("R6 overflow flag", f, sum[16]);
            end
        end

        // R5 run clear: internal then external activity
        load(16'h0010);
        wr(2'd0, cfg(0, 0, 0, 2'd0, 0, 0, 0));
        cycles(64);
        rd_cnt(v); chk("R5 run off internal", v, 16'h0010);
        wr(2'd0, cfg(0, 1, 1, 2'd0, 0, 0, 0));
        pulses(5);
        rd_cnt(v); chk("R5 run off external", v, 16'h0010);

        // R6/R7 sticky flag, write 1 ignored, write 0 clears
        load(16'hFFFF);
        wr(2'd0, cfg(1, 0, 0, 2'd0, 0, 0, 0));
        cycles(4);
        wr(2'd0, 8'h00);
        rd_cnt(v); chk("R6 wrap to zero", v, 16'h0000);
        rd_flag(f); chk("R6 flag set", f, 1'b1);
        wr(2'd3, 8'h01); cycles(20);
        rd_flag(f); chk("R7 write one ignored", f, 1'b1);
        wr(2'd3, 8'h00);
        rd_flag(f); chk("R7 write zero clears", f, 1'b0);

        // R7 set wins over clear in the same cycle (bypass edge, divide 1)
        load(16'hFFFF);
        wr(2'd0, cfg(1, 1, 1, 2'd0, 0, 0, 0));
        bus_addr = 2'd3; bus_wdata = 8'h00; bus_we = 1'b1; ext_clk_in = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_flag(f); chk("R7 set wins", f, 1'b1);
        rd_cnt(v); chk("R7 set wins count", v, 16'h0000);
        cycles(3); ext_clk_in = 1'b0; cycles(3);

        // R9 synchronized latency
        load(16'h0000);
        wr(2'd0, cfg(1, 1, 0, 2'd0, 0, 0, 0));
        ext_clk_in = 1'b1;
        cycles(2); rd_cnt(v); chk("R9 no count after two edges", v, 16'h0000);
        cycles(1); rd_cnt(v); chk("R9 count after third edge", v, 16'h0001);
        cycles(2); ext_clk_in = 1'b0; cycles(4);

        // R10 bypass latency
        load(16'h0000);
        wr(2'd0, cfg(1, 1, 1, 2'd0, 0, 0, 0));
        ext_clk_in = 1'b1;
        cycles(1); rd_cnt(v); chk("R10 count after first edge", v, 16'h0001);
        cycles(2); ext_clk_in = 1'b0; cycles(4);

        // R4/R9/R10 external counting over prescale values, both paths
        for (int byp = 0; byp < 2; byp++) begin
            for (int ps = 0; ps < 4; ps++) begin
                load(16'h0100);
                wr(2'd0, cfg(1, 1, byp[0], 2'(ps), 0, 0, 0));
                pulses(3 * (1 << ps));
                cycles(4);
                rd_cnt(v);
                chk(byp == 0 ? "R9 sync external count" : "R10 bypass external count",
                    v, 16'h0103);
            end
        end

        // R8 gate source/polarity/level sweep; the unselected input is opposite
        for (int gsel = 0; gsel < 2; gsel++) begin
            for (int ginv = 0; ginv < 2; ginv++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    logic [15:0] exp;
                    load(16'h0000);
                    gate_in = (gsel == 0) ? lvl[0] : ~lvl[0];
                    cmp_in  = (gsel == 1) ? lvl[0] : ~lvl[0];
                    wr(2'd0, cfg(1, 0, 0, 2'd0, 1, gsel[0], ginv[0]));
                    cycles(24);
                    rd_cnt(v);
                    exp = ((lvl ^ ginv) != 0) ? 16'd6 : 16'd0;
                    chk("R8 gate qualify", v, exp);
                end
            end
        end
        load(16'h0000);
        gate_in = 1'b0; cmp_in = 1'b0;
        wr(2'd0, cfg(1, 0, 0, 2'd0, 0, 0, 0));
        cycles(24);
        rd_cnt(v); chk("R8 gate disabled", v, 16'd6);

        // R11 count write resets the prescaler (divide 8)
        load(16'h0000);
        wr(2'd0, cfg(1, 0, 0, 2'd3, 0, 0, 0));
        cycles(20);
        wr(2'd1, 8'h40);
        cycles(28);
        rd_cnt(v); chk("R11 no increment before full division", v, 16'h0040);
        cycles(4);
        rd_cnt(v); chk("R11 increment after full division", v, 16'h0041);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule